// File: doc/BRIEF.md
# Serial Link Startup Handshake Controller

This block brings up one end of a point-to-point serial link pair. It watches the local transmitter's lock flag and the stream of already-decoded received frames. From these it drives the two link status bits, the receiver enable, the frequency-detector disable, the active-mode flag, the transmit frame-type select and the enable-data strobe that gates real payload onto the line.

Bring-up is a two-ended handshake. While neither status bit is set, the local transmitter sends fill type 0. Fill type 0 is a square-wave pattern that the far receiver uses to acquire frame lock. Once the local receiver has frame lock, this end raises status bit 1. It then disables its frequency detector, enters active mode and switches to sending fill type 1, which tells the far end that this end is ready. When a run of fill-type-1 frames arrives from the far end, status bit 0 rises and data transfer is enabled.

Loss of transmitter lock, or a run of error frames, drops the link back to the start. The word-width and speed options are consumed by the serializer datapath beside this block and do not enter the handshake.

Top module: `link_startup_ctrl`

## Requirements
- R1: `rx_enable` is low in every cycle that follows a cycle in which `tx_locked` was low. Once `tx_locked` is high, `rx_enable` rises one clock later.
- R2: Whenever both status bits are low, `tx_sel` is 2'b00, which selects fill type 0.
- R3: In acquisition, a run of LOCK_FRAMES (8) consecutive strobed, valid frames of type fill-0 (2'b00) or fill-1 (2'b01) declares frame lock. `stat1` and `fd_disable` then rise on the clock after the last frame of the run. An error frame (2'b11) or an invalid strobed frame restarts the run.
- R4: `fd_disable` rises first. `active` rises one clock after it, and `tx_sel` becomes 2'b01 (fill-1) one clock after `active`.
- R5: While sending fill-1, READY_FRAMES (4) consecutive strobed, valid fill-1 frames set `stat0` on the following clock. Any other strobed frame, including an invalid one, restarts the run. Fill-1 frames received before `tx_sel` reaches 2'b01 do not count toward this run.
- R6: When `stat0` is high, `en_data` is high and `tx_sel` is 2'b10 (data). `tx_sel` is 2'b10 only while `en_data` is high.
- R7: If `tx_locked` falls while `stat1` is high, all status, `active` and `en_data` outputs clear on the next clock, and `tx_sel` returns to 2'b00.
- R8: While `stat1` is high, ERR_FRAMES (4) consecutive strobed, valid error frames clear both status bits on the next clock. Any other strobed frame restarts that run.
- R9: Synchronous reset `rst` forces all outputs low, with `tx_sel` = 2'b00, from the next clock edge onward.
- R10: Frame inputs are ignored in cycles where `frame_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tx_locked | input | 1 | Transmitter PLL locked to the frame-rate strobe |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| rx_valid | input | 1 | Received frame decoded without fault |
| rx_type | input | 2 | Frame type: 00 fill-0, 01 fill-1, 10 data, 11 error |
| stat1 | output | 1 | Status bit 1: local frame lock held |
| stat0 | output | 1 | Status bit 0: far end ready |
| rx_enable | output | 1 | Receiver enable |
| fd_disable | output | 1 | Frequency-detector disable |
| active | output | 1 | Active-mode flag |
| tx_sel | output | 2 | Transmit frame select: 00 fill-0, 01 fill-1, 10 data |
| en_data | output | 1 | Enable-data to the transmitter |

## Verification
The assertions take the frame inputs to be meaningful only in the single cycle where `frame_stb` is high. They also take `tx_locked` and the frame inputs to be synchronous to `clk`. The stimulus changes every input only on the falling edge and holds it for whole cycles. It pairs each strobe with a defined `rx_type`. When it offers frame data with the strobe low, it does so on purpose, to show that such data is ignored.

// File: rtl/link_pkg.sv
package link_pkg;
  localparam logic [1:0] FR_FILL0 = 2'b00;
  localparam logic [1:0] FR_FILL1 = 2'b01;
  localparam logic [1:0] FR_DATA  = 2'b10;
  localparam logic [1:0] FR_ERR   = 2'b11;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_ACQ  = 3'd1,
    ST_FDIS = 3'd2,
    ST_ACT  = 3'd3,
    ST_RDY  = 3'd4,
    ST_DATA = 3'd5
  } link_state_e;
endpackage

// File: rtl/lsc_run_cnt.sv
// Counts consecutive strobed matches; pulses hit on the TARGET-th one.
module lsc_run_cnt #(
  parameter int TARGET = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb,
  input  logic match,
  output logic hit
);
  localparam int CW = $clog2(TARGET + 1);

  logic [CW-1:0] cnt;

  assign hit = stb && match && (cnt == CW'(TARGET - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (stb) begin
      if (!match || hit) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  // R3 / R5 / R8: a run never counts past its target
  a_r3_run_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(TARGET));
endmodule

// File: rtl/lsc_seq.sv
module lsc_seq
  import link_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_locked,
  input  logic        lock_hit,
  input  logic        ready_hit,
  input  logic        err_hit,
  output link_state_e state
);
  link_state_e nxt;

  always_comb begin
    nxt = state;
    if (state != ST_WAIT && !tx_locked) begin
      nxt = ST_WAIT;
    end else begin
      case (state)
        ST_WAIT: if (tx_locked) nxt = ST_ACQ;
        ST_ACQ:  if (lock_hit)  nxt = ST_FDIS;
        ST_FDIS: nxt = err_hit ? ST_WAIT : ST_ACT;
        ST_ACT:  nxt = err_hit ? ST_WAIT : ST_RDY;
        ST_RDY: begin
          if (err_hit)        nxt = ST_WAIT;
          else if (ready_hit) nxt = ST_DATA;
        end
        ST_DATA: if (err_hit) nxt = ST_WAIT;
        default: nxt = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT;
    else     state <= nxt;
  end

  // R5: data state is entered only from the fill-1 state
  a_r5_data_from_ready: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && $past(state) != ST_DATA) |-> $past(state) == ST_RDY);
endmodule

// File: rtl/link_startup_ctrl.sv
module link_startup_ctrl
  import link_pkg::*;
#(
  parameter int LOCK_FRAMES  = 8,
  parameter int READY_FRAMES = 4,
  parameter int ERR_FRAMES   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_locked,
  input  logic       frame_stb,
  input  logic       rx_valid,
  input  logic [1:0] rx_type,
  output logic       stat1,
  output logic       stat0,
  output logic       rx_enable,
  output logic       fd_disable,
  output logic       active,
  output logic [1:0] tx_sel,
  output logic       en_data
);
  link_state_e state;
  logic lock_hit, ready_hit, err_hit;
  logic fill_ok, fill1_ok, err_ok;

  assign fill_ok  = rx_valid && (rx_type == FR_FILL0 || rx_type == FR_FILL1);
  assign fill1_ok = rx_valid && (rx_type == FR_FILL1);
  assign err_ok   = rx_valid && (rx_type == FR_ERR);

  lsc_run_cnt #(.TARGET(LOCK_FRAMES)) u_lock_cnt (
    .clk(clk), .rst(rst), .clr(state != ST_ACQ),
    .stb(frame_stb), .match(fill_ok), .hit(lock_hit));

  lsc_run_cnt #(.TARGET(READY_FRAMES)) u_ready_cnt (
    .clk(clk), .rst(rst), .clr(state != ST_RDY),
    .stb(frame_stb), .match(fill1_ok), .hit(ready_hit));

  lsc_run_cnt #(.TARGET(ERR_FRAMES)) u_err_cnt (
    .clk(clk), .rst(rst), .clr(!stat1),
    .stb(frame_stb), .match(err_ok), .hit(err_hit));

  lsc_seq u_seq (
    .clk(clk), .rst(rst), .tx_locked(tx_locked),
    .lock_hit(lock_hit), .ready_hit(ready_hit), .err_hit(err_hit),
    .state(state));

  assign rx_enable  = (state != ST_WAIT);
  assign stat1      = (state == ST_FDIS) || (state == ST_ACT) ||
                      (state == ST_RDY)  || (state == ST_DATA);
  assign fd_disable = stat1;
  assign active     = (state == ST_ACT) || (state == ST_RDY) || (state == ST_DATA);
  assign stat0      = (state == ST_DATA);
  assign en_data    = (state == ST_DATA);
  assign tx_sel     = (state == ST_DATA) ? FR_DATA :
                      (state == ST_RDY)  ? FR_FILL1 : FR_FILL0;

  // R1: receiver stays off after any cycle without transmitter lock
  a_r1_rx_off_without_lock: assert property (@(posedge clk) disable iff (rst)
    !tx_locked |=> !rx_enable);
  // R2: idle status sends fill-0
  a_r2_fill0_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!stat1 && !stat0) |-> tx_sel == 2'b00);
  // R3: status bit 1 implies a running receiver
  a_r3_stat1_needs_rx: assert property (@(posedge clk) disable iff (rst)
    stat1 |-> rx_enable);
  // R4: frequency detector off before active mode
  a_r4_fd_before_active: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(fd_disable));
  // R4: fill-1 only after active mode was already set
  a_r4_active_before_fill1: assert property (@(posedge clk) disable iff (rst)
    (tx_sel == 2'b01 && $past(tx_sel) != 2'b01) |-> $past(active));
  // R6: data select only with enable-data and both status bits
  a_r6_data_needs_both: assert property (@(posedge clk) disable iff (rst)
    (tx_sel == 2'b10) |-> (en_data && stat1 && stat0));
  // R7: lock loss clears everything on the next clock
  a_r7_lock_loss_clears: assert property (@(posedge clk) disable iff (rst)
    (stat1 && !tx_locked) |=> (!stat1 && !stat0 && !active && !en_data));
endmodule

// File: tb/link_startup_ctrl_bench.sv
module link_startup_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_locked = 1'b0, frame_stb = 1'b0, rx_valid = 1'b0;
  logic [1:0] rx_type = 2'b00;
  logic stat1, stat0, rx_enable, fd_disable, active, en_data;
  logic [1:0] tx_sel;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  link_startup_ctrl u_link_startup_ctrl (
    .clk(clk), .rst(rst), .tx_locked(tx_locked), .frame_stb(frame_stb),
    .rx_valid(rx_valid), .rx_type(rx_type), .stat1(stat1), .stat0(stat0),
    .rx_enable(rx_enable), .fd_disable(fd_disable), .active(active),
    .tx_sel(tx_sel), .en_data(en_data));

  // expected {stat1, stat0, rx_enable, fd_disable, active, tx_sel[1:0], en_data}
  localparam logic [7:0] E_WAIT = 8'b0000_0000;
  localparam logic [7:0] E_ACQ  = 8'b0010_0000;
  localparam logic [7:0] E_FDIS = 8'b1011_0000;
  localparam logic [7:0] E_ACT  = 8'b1011_1000;
  localparam logic [7:0] E_RDY  = 8'b1011_1010;
  localparam logic [7:0] E_DATA = 8'b1111_1101;
  localparam logic [1:0] F0 = 2'b00, F1 = 2'b01, DT = 2'b10, ER = 2'b11;
  localparam int NV = 30;

  // {lock, stb, valid, type[1:0], reps[3:0], expected[7:0]}
  localparam logic [16:0] VEC [NV] = '{
    {3'b011, F0, 4'd3,  E_WAIT},  // R1 R2 no lock, receiver off, fill-0
    {3'b101, F0, 4'd10, E_ACQ },  // R10 frames without strobe ignored
    {3'b111, F0, 4'd5,  E_ACQ },  // R3
    {3'b111, ER, 4'd1,  E_ACQ },  // R3 error restarts run
    {3'b111, F0, 4'd7,  E_ACQ },  // R3
    {3'b111, F1, 4'd1,  E_FDIS},  // R3 eighth frame locks
    {3'b100, F0, 4'd1,  E_ACT },  // R4
    {3'b100, F0, 4'd1,  E_RDY },  // R4
    {3'b111, F1, 4'd3,  E_RDY },  // R5
    {3'b111, F0, 4'd1,  E_RDY },  // R5 fill-0 restarts
    {3'b111, F1, 4'd3,  E_RDY },  // R5
    {3'b110, F1, 4'd1,  E_RDY },  // R5 invalid restarts
    {3'b111, F1, 4'd3,  E_RDY },  // R5
    {3'b111, F1, 4'd1,  E_DATA},  // R6 fourth fill-1
    {3'b100, F0, 4'd2,  E_DATA},  // R6 holds
    {3'b111, ER, 4'd3,  E_DATA},  // R8
    {3'b111, DT, 4'd1,  E_DATA},  // R8 data frame restarts
    {3'b111, ER, 4'd3,  E_DATA},  // R8
    {3'b111, ER, 4'd1,  E_WAIT},  // R8 fourth error clears
    {3'b100, F0, 4'd1,  E_ACQ },  // R1 relock
    {3'b111, F0, 4'd8,  E_FDIS},  // R3
    {3'b100, F0, 4'd2,  E_RDY },  // R4
    {3'b111, F1, 4'd4,  E_DATA},  // R5
    {3'b000, F0, 4'd1,  E_WAIT},  // R7 lock loss
    {3'b011, F0, 4'd8,  E_WAIT},  // R1 no lock, frames ignored
    {3'b100, F0, 4'd1,  E_ACQ },  // R1
    {3'b111, F1, 4'd8,  E_FDIS},  // R3 fill-1 counts for frame lock
    {3'b111, F1, 4'd2,  E_RDY },  // R5 fill-1 before select ignored
    {3'b111, F1, 4'd3,  E_RDY },  // R5
    {3'b111, F1, 4'd1,  E_DATA}   // R5
  };
  localparam int VREQ [NV] = '{1,10,3,3,3,3,4,4,5,5,5,5,5,6,6,8,8,8,8,1,
                               3,4,5,7,1,1,3,5,5,5};

  function automatic logic [7:0] outs();
    return {stat1, stat0, rx_enable, fd_disable, active, tx_sel, en_data};
  endfunction

  task automatic check(input int req, input logic [7:0] exp);
    n_run++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL R%0d got %b expected %b", req, outs(), exp);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(9, E_WAIT);  // R9 reset state
    @(negedge clk) rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      for (int r = 0; r < int'(VEC[v][11:8]); r++) begin
        @(negedge clk);
        tx_locked = VEC[v][16];
        frame_stb = VEC[v][15];
        rx_valid  = VEC[v][14];
        rx_type   = VEC[v][13:12];
        @(posedge clk);
      end
      #1 check(VREQ[v], VEC[v][7:0]);
    end
    // R9 reset from the data state
    @(negedge clk);
    frame_stb = 1'b0; tx_locked = 1'b1; rst = 1'b1;
    @(posedge clk);
    #1 check(9, E_WAIT);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #1 check(9, E_ACQ);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule